// File: doc/BRIEF.md
# Light-Load Pulse-Skipping Controller

This block sits between a fixed-frequency PWM cycle controller and the gate drivers of a synchronous step-down stage. When pulse-skipping is selected it takes over both switch enables. At each period tick it looks at the output-low comparator. If the output is below its setpoint, the block fires one high-side pulse of fixed length, waits a short dead time, and then holds the low-side switch on until the inductor-current comparator reports that the current has fallen under its threshold. If the output is above the setpoint, the block leaves both switches off for that whole period.

Skip mode is chosen once, when enable rises, and is kept until enable falls. When skip mode is not selected, the PWM controller's two switch requests pass straight through. A saturating counter reports how many periods in a row have been skipped since the last pulse, so a bench or a monitor can observe the effective switching rate.

Top module: `skip_pulse_ctrl`

## Requirements
- R1: `skip_sel` is captured at the clock edge that first samples `en` high, and `skip_active` shows the captured value from the next cycle. Changes of `skip_sel` while `en` stays high have no effect. A clock edge that samples `en` low clears `skip_active`.
- R2: While `skip_active` is 0, `hs_on` equals `pwm_hs_in` and `ls_on` equals `pwm_ls_in` in the same cycle.
- R3: In skip mode, with no pulse in progress, a `period_tick` sampled together with `below_sp`=1 raises `hs_on` in the next cycle. `hs_on` then stays high for exactly ON_CLKS cycles.
- R4: After the high-side pulse, both `hs_on` and `ls_on` stay low for exactly DEAD_CLKS cycles, and then `ls_on` rises.
- R5: `ls_on` stays high until an edge samples `zero_x`=1. From the next cycle it is low, and it stays low until the next pulse.
- R6: In skip mode, with no pulse in progress, a `period_tick` sampled with `below_sp`=0 keeps both switches off and raises `skip_count` by one in the next cycle.
- R7: `skip_count` saturates at 2^CNT_W-1 and holds there on further skipped periods.
- R8: `skip_count` reads 0 in the cycle in which a new high-side pulse begins.
- R9: A `period_tick` that arrives while a pulse is in progress (high-side, dead time or low-side phase) starts no pulse and leaves `skip_count` unchanged.
- R10: In skip mode, `hs_on` and `ls_on` are never high in the same cycle.
- R11: Under reset, `skip_active` is 0 and `skip_count` is 0, and the switch outputs follow the PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable; its rising edge captures the mode |
| skip_sel | input | 1 | 1 selects pulse-skipping, 0 selects plain PWM |
| period_tick | input | 1 | One-cycle strobe at the start of each switching period |
| below_sp | input | 1 | Output-below-setpoint comparator result |
| zero_x | input | 1 | Inductor current below the zero-crossing threshold |
| pwm_hs_in | input | 1 | High-side request from the PWM cycle controller |
| pwm_ls_in | input | 1 | Low-side request from the PWM cycle controller |
| hs_on | output | 1 | High-side switch enable |
| ls_on | output | 1 | Low-side switch enable |
| skip_active | output | 1 | Skip mode is in force |
| skip_count | output | CNT_W | Consecutive skipped periods since the last pulse, saturating |

## Verification
The assertions take for granted that `period_tick` is a single-cycle strobe, and that DEAD_CLKS is at least one. The pulse-width check accepts a pulse that is cut short only when the run condition was lost at the preceding edge. The stimulus keeps ticks between 50 and 120 cycles apart, which is longer than the high-side pulse plus the dead time. It drops `en` only at a period start, so a high-side pulse is never cut. `zero_x` and the PWM requests are random on every cycle, and `skip_sel` is toggled while enabled to show that it is ignored. A few periods are made short enough that their ticks land inside the low-side phase.

// File: rtl/skip_pkg.sv
// Shared types for the pulse-skipping controller.
package skip_pkg;
    // Phase of one skip-mode pulse sequence.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_DEAD = 2'd2,
        PH_LOW  = 2'd3
    } skip_phase_t;
endpackage

// File: rtl/skip_mode_latch.sv
// Captures the skip-mode choice at the rising edge of enable and holds it
// until enable is sampled low. Assumes en is synchronous to clk.
module skip_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic skip_sel,
    output logic mode_q
);
    logic en_q;

    // Track enable and freeze the mode at its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            en_q <= en;
            if (!en)
                mode_q <= 1'b0;
            else if (!en_q)
                mode_q <= skip_sel;
        end
    end

    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q) |=> $stable(mode_q));

    p_mode_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mode_q);
endmodule

// File: rtl/skip_pulse_seq.sv
// Sequencer for one skip-mode pulse: fixed high-side on-time, break-before-
// make gap, then low side held until the zero-crossing comparator trips.
// Assumes DEAD_CLKS >= 1 and ON_CLKS >= 1; ticks outside idle are ignored.
module skip_pulse_seq
    import skip_pkg::*;
#(
    parameter int ON_CLKS   = 33,
    parameter int DEAD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic below_sp,
    input  logic zero_x,
    output logic hs_req,
    output logic ls_req,
    output logic pulse_start,
    output logic skip_evt
);
    localparam int TMAX = (ON_CLKS > DEAD_CLKS) ? ON_CLKS : DEAD_CLKS;
    localparam int TW   = $clog2(TMAX + 1);

    skip_phase_t     phase;
    logic [TW-1:0]   tmr;

    // Per-period decision, only taken from idle.
    always_comb begin
        pulse_start = run && (phase == PH_IDLE) && tick && below_sp;
        skip_evt    = run && (phase == PH_IDLE) && tick && !below_sp;
    end

    // Phase and timer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            tmr   <= '0;
        end else if (!run) begin
            phase <= PH_IDLE;
            tmr   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (pulse_start) begin
                    phase <= PH_HIGH;
                    tmr   <= TW'(ON_CLKS - 1);
                end
                PH_HIGH: if (tmr == '0) begin
                    phase <= PH_DEAD;
                    tmr   <= TW'(DEAD_CLKS - 1);
                end else begin
                    tmr <= tmr - 1'b1;
                end
                PH_DEAD: if (tmr == '0) begin
                    phase <= PH_LOW;
                end else begin
                    tmr <= tmr - 1'b1;
                end
                PH_LOW: if (zero_x) begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Switch requests decoded from the phase.
    always_comb begin
        hs_req = (phase == PH_HIGH);
        ls_req = (phase == PH_LOW);
    end

    // Checker-only run length of the high-side request.
    logic [15:0] chk_hs_len;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_hs_len <= '0;
        else
            chk_hs_len <= hs_req ? chk_hs_len + 16'd1 : 16'd0;
    end

    p_hs_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_req && chk_hs_len != 16'd0 && $past(run)) |-> (chk_hs_len == 16'(ON_CLKS)));

    p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> hs_req);

    p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_req) |-> !$past(hs_req));

    p_zx_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_req && zero_x) |=> !ls_req);

    p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_evt |=> (!hs_req && !ls_req));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req || ls_req) |-> (!pulse_start && !skip_evt));
endmodule

// File: rtl/skip_run_counter.sv
// Counts consecutive skipped periods, saturating at all-ones; cleared by a
// pulse start or whenever skip mode is not running.
module skip_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pulse_start,
    input  logic             skip_evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Saturating skipped-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            count <= '0;
        else if (pulse_start)
            count <= '0;
        else if (skip_evt && count != CMAX)
            count <= count + 1'b1;
    end

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && skip_evt && count == CMAX) |=> (count == CMAX));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> (count == '0));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && skip_evt && count != CMAX) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/skip_pulse_ctrl.sv
// Top of the light-load pulse-skipping controller. In skip mode the switch
// enables come from the pulse sequencer; otherwise the PWM controller's
// requests pass through unchanged. Assumes all inputs are synchronous to clk.
module skip_pulse_ctrl #(
    parameter int ON_CLKS   = 33,
    parameter int DEAD_CLKS = 2,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             skip_sel,
    input  logic             period_tick,
    input  logic             below_sp,
    input  logic             zero_x,
    input  logic             pwm_hs_in,
    input  logic             pwm_ls_in,
    output logic             hs_on,
    output logic             ls_on,
    output logic             skip_active,
    output logic [CNT_W-1:0] skip_count
);
    logic mode_q;
    logic run;
    logic hs_req, ls_req, pulse_start, skip_evt;

    skip_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .skip_sel (skip_sel),
        .mode_q   (mode_q)
    );

    // Sequencer and counter run only while enabled in skip mode.
    always_comb run = en && mode_q;

    skip_pulse_seq #(
        .ON_CLKS   (ON_CLKS),
        .DEAD_CLKS (DEAD_CLKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .tick        (period_tick),
        .below_sp    (below_sp),
        .zero_x      (zero_x),
        .hs_req      (hs_req),
        .ls_req      (ls_req),
        .pulse_start (pulse_start),
        .skip_evt    (skip_evt)
    );

    skip_run_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .pulse_start (pulse_start),
        .skip_evt    (skip_evt),
        .count       (skip_count)
    );

    // Select switch drive source by captured mode.
    always_comb begin
        skip_active = mode_q;
        hs_on       = mode_q ? hs_req : pwm_hs_in;
        ls_on       = mode_q ? ls_req : pwm_ls_in;
    end

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_active |-> !(hs_on && ls_on));
endmodule

// File: tb/tb_skip_pulse_ctrl.sv
// Self-checking bench: directed corner cases, then seeded random periods,
// compared against a requirement-level cycle model.
module tb_skip_pulse_ctrl;
    localparam int ON_CLKS   = 33;
    localparam int DEAD_CLKS = 2;
    localparam int CNT_W     = 4;
    localparam int CMAX      = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n, en, skip_sel, period_tick, below_sp, zero_x, pwm_hs_in, pwm_ls_in;
    logic hs_on, ls_on, skip_active;
    logic [CNT_W-1:0] skip_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    skip_pulse_ctrl #(.ON_CLKS(ON_CLKS), .DEAD_CLKS(DEAD_CLKS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .skip_sel(skip_sel),
        .period_tick(period_tick), .below_sp(below_sp), .zero_x(zero_x),
        .pwm_hs_in(pwm_hs_in), .pwm_ls_in(pwm_ls_in),
        .hs_on(hs_on), .ls_on(ls_on), .skip_active(skip_active),
        .skip_count(skip_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Requirement-level model, advanced on each rising edge.
    bit m_enq, m_mode;
    int m_ph, m_tmr, m_skip;
    int n_pulse = 0, n_skip = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_enq = 0; m_mode = 0; m_ph = 0; m_tmr = 0; m_skip = 0;
        end else begin
            if (!(en && m_mode)) begin
                m_ph = 0; m_skip = 0;                    // R1: not running
            end else begin
                case (m_ph)
                    0: if (period_tick) begin
                        if (below_sp) begin
                            m_ph = 1; m_tmr = ON_CLKS; m_skip = 0; n_pulse++;   // R3, R8
                        end else begin
                            if (m_skip < CMAX) m_skip++;                         // R6, R7
                            n_skip++;
                        end
                    end
                    1: begin m_tmr--; if (m_tmr == 0) begin m_ph = 2; m_tmr = DEAD_CLKS; end end
                    2: begin m_tmr--; if (m_tmr == 0) m_ph = 3; end            // R4
                    default: if (zero_x) m_ph = 0;                             // R5; ticks ignored R9
                endcase
            end
            if (!en) m_mode = 0;
            else if (!m_enq) m_mode = skip_sel;
            m_enq = en;
        end
    end

    // Model comparison plus independent width and gap measurements.
    int hs_run = 0, gap = 0;
    bit prev_hs = 0, prev_ls = 0, after_hs = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 skip_active", skip_active, m_mode);
            chk(m_mode ? "R3 hs_on" : "R2 hs_on", hs_on, m_mode ? (m_ph == 1) : pwm_hs_in);
            chk(m_mode ? "R5 ls_on" : "R2 ls_on", ls_on, m_mode ? (m_ph == 3) : pwm_ls_in);
            chk("R6/R7 skip_count", skip_count, m_skip);
            if (skip_active) begin
                if (hs_on && ls_on) chk("R10 overlap", 1, 0);
                if (hs_on) hs_run++;
                if (prev_hs && !hs_on && en) begin
                    chk("R3 pulse width", hs_run, ON_CLKS);
                    after_hs = 1; gap = 0;
                end
                if (!hs_on) hs_run = 0;
                if (after_hs && !hs_on && !ls_on) gap++;
                if (after_hs && !prev_ls && ls_on) begin
                    chk("R4 dead gap", gap, DEAD_CLKS);
                    after_hs = 0;
                end
            end else begin
                hs_run = 0; after_hs = 0;
            end
            prev_hs = hs_on && skip_active;
            prev_ls = ls_on && skip_active;
        end
    end

    task automatic nxt();
        @(posedge clk); #2;
    endtask
    task automatic look();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; en = 0; skip_sel = 0; period_tick = 0; below_sp = 0;
        zero_x = 0; pwm_hs_in = 0; pwm_ls_in = 0;
        repeat (4) nxt();
        look();
        chk("R11 reset skip_active", skip_active, 0);
        chk("R11 reset skip_count", skip_count, 0);
        chk("R11 reset hs_on", hs_on, 0);
        nxt(); rst_n = 1;

        // R2 passthrough, disabled and enabled in PWM mode
        pwm_hs_in = 1; pwm_ls_in = 0; look();
        chk("R2 pass hs", hs_on, 1);
        nxt(); en = 1; skip_sel = 0; pwm_hs_in = 0; pwm_ls_in = 1;
        nxt(); look();
        chk("R2 pass ls", ls_on, 1);
        chk("R1 pwm mode", skip_active, 0);
        nxt(); en = 0; pwm_ls_in = 0;
        nxt();

        // R1 capture at enable rise, later changes ignored
        en = 1; skip_sel = 1;
        nxt(); look();
        chk("R1 captured", skip_active, 1);
        nxt(); skip_sel = 0; pwm_hs_in = 1;
        repeat (3) nxt();
        look();
        chk("R1 frozen", skip_active, 1);
        chk("R2 ignored in skip", hs_on, 0);

        // R3, R8: pulse start
        nxt(); period_tick = 1; below_sp = 1;
        nxt(); period_tick = 0; look();
        chk("R3 hs rises", hs_on, 1);
        chk("R8 count clear", skip_count, 0);
        repeat (40) nxt();
        look();
        chk("R5 ls held", ls_on, 1);

        // R9: tick inside the low-side phase
        nxt(); period_tick = 1; below_sp = 1;
        nxt(); period_tick = 0;
        nxt(); look();
        chk("R9 no new pulse", hs_on, 0);
        chk("R9 ls unchanged", ls_on, 1);
        chk("R9 count unchanged", skip_count, 0);

        // R5: zero crossing ends low side
        zero_x = 1; nxt(); zero_x = 0; look();
        chk("R5 ls off", ls_on, 0);

        // R6, R7: skipped periods and saturation
        for (int i = 0; i < 20; i++) begin
            nxt(); period_tick = 1; below_sp = 0;
            nxt(); period_tick = 0; look();
            if (i == 0) begin
                chk("R6 first skip", skip_count, 1);
                chk("R6 switches off", hs_on | ls_on, 0);
            end
        end
        chk("R7 saturated", skip_count, CMAX);
        nxt(); period_tick = 1; below_sp = 1;
        nxt(); period_tick = 0; look();
        chk("R8 clear after saturation", skip_count, 0);
        chk("R3 hs after skips", hs_on, 1);

        // Random periods
        for (int p = 0; p < 250; p++) begin
            int len;
            len = ((p % 17) == 5) ? 50 : 60 + int'($urandom % 61);
            nxt();
            if (($urandom % 25) == 0) begin
                en = 0; nxt(); nxt();
                en = 1; skip_sel = ($urandom % 4) != 0;
                nxt();
            end
            period_tick = 1; below_sp = ($urandom % 3) == 0;
            zero_x = ($urandom % 8) == 0;
            pwm_hs_in = $urandom % 2; pwm_ls_in = $urandom % 2;
            for (int c = 1; c < len; c++) begin
                nxt();
                period_tick = 0;
                below_sp  = $urandom % 2;
                zero_x    = ($urandom % 8) == 0;
                pwm_hs_in = $urandom % 2; pwm_ls_in = $urandom % 2;
                if (($urandom % 16) == 0) skip_sel = ~skip_sel;   // R1 ignored
            end
        end
        nxt(); look();
        $display("pulses %0d, skipped periods %0d", n_pulse, n_skip);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule